// File: doc/BRIEF.md
# Current Channel Auto-Ranging Gain Controller

This block decides which of three amplifier settings a single current-sensing channel uses. On every sample strobe it looks at two things. The first is the unconditioned ADC word, which shows whether the amplifier is driving the converter into clipping. The second is the amplitude of the filtered current, which shows whether the signal is too small to measure well. When the signal is clipping, the gain drops one step. When the signal is small, the gain rises one step. A gain change is never more than one step at a time.

After each change, a programmable number of sample strobes must pass before another change is allowed. This hold-off lets the analog front end settle, and it stops the setting from hunting between two steps. The block outputs the setting as a 2-bit code and as a one-hot index that selects the matching gain calibration coefficient. It also gives a one-cycle pulse on every change, so that downstream accumulators can throw away the data of the interrupted cycle.

Top module: `agc_gain_ctrl`

## Requirements
- R1: After reset, `gain_sel` is 0 (lowest gain), `coef_sel` is 3'b001 and `switched` is 0. The hold-off starts already expired, so the first strobed sample may cause a switch.
- R2: On a strobed sample where `amp_filt` is strictly less than `thr_small`, the gain steps up by one.
- R3: On a strobed sample where `smp_raw` is strictly below `sat_lo` or strictly above `sat_hi`, the gain steps down by one. A raw value equal to either limit is not saturation.
- R4: When saturation and small amplitude are seen on the same sample, saturation wins. The gain steps down, or stays put at the lowest setting, and never steps up.
- R5: The gain never goes above 2 (highest) or below 0 (lowest). A request beyond either end is ignored and gives no pulse.
- R6: After a switch, the next `hold_len` strobed samples cannot cause a switch. The strobed sample after those can. With `hold_len` equal to 0, consecutive samples may switch.
- R7: `gain_sel` and `coef_sel` take their new value at the clock edge that registers the deciding strobe. `switched` is high for exactly the one cycle that follows that edge.
- R8: The gain code is 0 = low, 1 = medium, 2 = high. `coef_sel` is one-hot, with bit 0 for low, bit 1 for medium and bit 2 for high.
- R9: Cycles without `smp_vld` change no output and do not advance the hold-off count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per new sample |
| smp_raw | input | RAW_W (10) | Unconditioned ADC sample, 0..1023 |
| amp_filt | input | AMP_W (20) | Magnitude of the filtered current |
| thr_small | input | AMP_W (20) | Small-signal threshold for stepping up |
| sat_lo | input | RAW_W (10) | Low clipping limit |
| sat_hi | input | RAW_W (10) | High clipping limit |
| hold_len | input | HOLD_W (8) | Hold-off length, in samples |
| gain_sel | output | 2 | Amplifier setting |
| coef_sel | output | 3 | One-hot calibration coefficient index |
| switched | output | 1 | One-cycle pulse on each gain change |

## Verification
Every result is one register stage away from the strobe that causes it. `gain_sel` and `coef_sel` hold their new value from the edge that registers the strobe, and `switched` is high only during the following cycle. The bench drives each strobe on a falling edge and drops it on the next falling edge. It samples all three outputs at that second falling edge, half a cycle after the deciding edge. It then checks one idle cycle later that the pulse has cleared and that nothing moved without a strobe. The hold-off tests count strobes, not cycles, and they put idle gaps inside the window to show that the gaps do not shorten it.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [1:0] {
        GAIN_LO  = 2'd0,
        GAIN_MID = 2'd1,
        GAIN_HI  = 2'd2
    } gain_e;

    typedef struct packed {
        gain_e      gain;
        logic [2:0] coef;
        logic       sw;
    } ctrl_state_t;

    function automatic logic [2:0] gain_to_coef(gain_e g);
        case (g)
            GAIN_LO:  return 3'b001;
            GAIN_MID: return 3'b010;
            default:  return 3'b100;
        endcase
    endfunction
endpackage

// File: rtl/agc_level_detect.sv
module agc_level_detect #(
    parameter int RAW_W = 10,
    parameter int AMP_W = 20
) (
    input  logic [RAW_W-1:0] smp_raw,
    input  logic [AMP_W-1:0] amp_filt,
    input  logic [AMP_W-1:0] thr_small,
    input  logic [RAW_W-1:0] sat_lo,
    input  logic [RAW_W-1:0] sat_hi,
    output logic             is_sat,
    output logic             is_small
);
    always_comb begin
        is_sat   = (smp_raw < sat_lo) || (smp_raw > sat_hi);
        is_small = (amp_filt < thr_small);
    end
endmodule

// File: rtl/agc_holdoff.sv
module agc_holdoff #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [HOLD_W-1:0] len,
    output logic              busy
);
    logic [HOLD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len;
        else if (step && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R6
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

    // R9
    idle_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int RAW_W  = 10,
    parameter int AMP_W  = 20,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [RAW_W-1:0]  smp_raw,
    input  logic [AMP_W-1:0]  amp_filt,
    input  logic [AMP_W-1:0]  thr_small,
    input  logic [RAW_W-1:0]  sat_lo,
    input  logic [RAW_W-1:0]  sat_hi,
    input  logic [HOLD_W-1:0] hold_len,
    output logic [1:0]        gain_sel,
    output logic [2:0]        coef_sel,
    output logic              switched
);
    localparam ctrl_state_t RESET_ST = '{gain: GAIN_LO, coef: 3'b001, sw: 1'b0};

    ctrl_state_t st_d, st_q;
    logic        is_sat, is_small, busy, do_switch;

    agc_level_detect #(.RAW_W(RAW_W), .AMP_W(AMP_W)) u_detect (
        .smp_raw  (smp_raw),
        .amp_filt (amp_filt),
        .thr_small(thr_small),
        .sat_lo   (sat_lo),
        .sat_hi   (sat_hi),
        .is_sat   (is_sat),
        .is_small (is_small)
    );

    agc_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .step (smp_vld),
        .load (do_switch),
        .len  (hold_len),
        .busy (busy)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sw   = 1'b0;
        do_switch = 1'b0;
        if (smp_vld && !busy) begin
            if (is_sat) begin
                if (st_q.gain != GAIN_LO) begin
                    st_d.gain = gain_e'(st_q.gain - 2'd1);
                    do_switch = 1'b1;
                end
            end else if (is_small && (st_q.gain != GAIN_HI)) begin
                st_d.gain = gain_e'(st_q.gain + 2'd1);
                do_switch = 1'b1;
            end
        end
        st_d.sw   = do_switch;
        st_d.coef = gain_to_coef(st_d.gain);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign gain_sel = st_q.gain;
    assign coef_sel = st_q.coef;
    assign switched = st_q.sw;

    // R5
    gain_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_sel != 2'd3);

    // R8
    coef_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coef_sel) == 1);

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switched |-> ((gain_sel == $past(gain_sel) + 2'd1) ||
                      (gain_sel == $past(gain_sel) - 2'd1)));

    // R9
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(gain_sel) && !switched));

    // R6
    holdoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && busy) |=> !switched);

    // R4
    sat_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !busy && is_sat && is_small) |=> (gain_sel <= $past(gain_sel)));
endmodule

// File: tb/test_agc_gain_ctrl.sv
module test_agc_gain_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [9:0]  smp_raw = 10'd512;
    logic [19:0] amp_filt = 20'd500;
    logic [19:0] thr_small = 20'd100;
    logic [9:0]  sat_lo = 10'd8;
    logic [9:0]  sat_hi = 10'd1015;
    logic [7:0]  hold_len = 8'd0;
    logic [1:0]  gain_sel;
    logic [2:0]  coef_sel;
    logic        switched;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    agc_gain_ctrl i_agc_gain_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_raw(smp_raw),
        .amp_filt(amp_filt), .thr_small(thr_small), .sat_lo(sat_lo),
        .sat_hi(sat_hi), .hold_len(hold_len), .gain_sel(gain_sel),
        .coef_sel(coef_sel), .switched(switched)
    );

    typedef struct packed {
        logic [9:0]  raw;
        logic [19:0] amp;
        logic [1:0]  gain;
        logic        sw;
    } vec_t;

    // hold_len = 0, thr_small = 100, sat_lo = 8, sat_hi = 1015
    localparam vec_t VEC [11] = '{
        '{10'd512,  20'd50,  2'd1, 1'b1},  // R2 up
        '{10'd512,  20'd50,  2'd2, 1'b1},  // R2 up, R6 zero hold
        '{10'd512,  20'd50,  2'd2, 1'b0},  // R5 ceiling
        '{10'd512,  20'd500, 2'd2, 1'b0},  // quiet
        '{10'd1020, 20'd500, 2'd1, 1'b1},  // R3 above high
        '{10'd3,    20'd50,  2'd0, 1'b1},  // R4 priority
        '{10'd0,    20'd50,  2'd0, 1'b0},  // R5 floor, R4 no up
        '{10'd1015, 20'd500, 2'd0, 1'b0},  // R3 equal high limit
        '{10'd8,    20'd99,  2'd1, 1'b1},  // R3 equal low limit, R2
        '{10'd512,  20'd100, 2'd1, 1'b0},  // R2 equal threshold
        '{10'd1016, 20'd100, 2'd0, 1'b1}   // R3
    };

    function automatic logic [2:0] exp_coef(logic [1:0] g);
        return (g == 2'd0) ? 3'b001 : (g == 2'd1) ? 3'b010 : 3'b100;
    endfunction

    task automatic check(string req, logic [1:0] g, logic sw);
        total++;
        if (gain_sel !== g || switched !== sw || coef_sel !== exp_coef(g)) begin
            bad++;
            $display("FAIL %s: gain=%0d coef=%b sw=%0b expected gain=%0d coef=%b sw=%0b",
                     req, gain_sel, coef_sel, switched, g, exp_coef(g), sw);
        end
    endtask

    task automatic sample(logic [9:0] raw, logic [19:0] amp);
        @(negedge clk);
        smp_raw  = raw;
        amp_filt = amp;
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1 reset", 2'd0, 1'b0);

        for (int i = 0; i < 11; i++) begin
            sample(VEC[i].raw, VEC[i].amp);
            check("R2/R3/R4/R5 vector", VEC[i].gain, VEC[i].sw);
            idle(1);
            check("R7 pulse clears", VEC[i].gain, 1'b0);
        end

        // R9: no strobe, small amplitude and clipping present, no change
        smp_raw  = 10'd0;
        amp_filt = 20'd0;
        idle(5);
        check("R9 no strobe", 2'd0, 1'b0);

        // R1: hold-off expired at reset even with a long hold
        hold_len = 8'd5;
        do_reset();
        sample(10'd512, 20'd10);
        check("R1 first sample switches", 2'd1, 1'b1);
        // R6 with R9: idle gaps do not count
        idle(20);
        for (int i = 0; i < 5; i++) begin
            sample(10'd512, 20'd10);
            check("R6 blocked", 2'd1, 1'b0);
            idle(3);
        end
        sample(10'd512, 20'd10);
        check("R6 released", 2'd2, 1'b1);
        // R6: saturation blocked too
        sample(10'd1023, 20'd500);
        check("R6 sat blocked", 2'd2, 1'b0);
        for (int i = 0; i < 4; i++) sample(10'd512, 20'd500);
        sample(10'd1023, 20'd500);
        check("R3 sat after hold", 2'd1, 1'b1);
        idle(1);
        check("R7 single pulse", 2'd1, 1'b0);

        // R1 again after mid-run reset
        do_reset();
        check("R1 reset from mid", 2'd0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule